// File: doc/BRIEF.md
# Pulse-Width Bit Line Codec

This block serializes and deserializes bytes on a single bus line that returns to zero after every bit. The length of the high pulse carries the bit value. A short high pulse means zero and a long one means one. Each pulse is followed by a short low gap. After the eighth bit the gap is stretched to the long length, so that the far end has time to handle the byte. Bytes go out most significant bit first.

The receive side synchronizes the line into the local clock with a two-flop chain. It counts prescaler ticks while the line is high. On each falling edge it classifies the pulse by its length:

- below a glitch limit, the pulse is an error;
- at or above a start length, the pulse is a start marker;
- otherwise it is a data bit, decided against a midway threshold.

Eight data bits make a byte, which is reported with a one-cycle strobe. An error or a start marker throws away any partly built byte.

All durations are parameters counted in ticks of a prescaled clock. One tick is `TICK_DIV` clock cycles. The transmitter takes a byte only while idle, with a ready/valid handshake. It pulses a done strobe once the stretched final gap has ended. Driver enable, bus arbitration and start-marker generation belong to the surrounding logic.

Top module: `pwl_codec`

## Requirements
- R1: A transmitted zero bit is a high period of exactly T_SHORT ticks, followed by a low gap of T_SHORT ticks when it is not the last bit of the byte. One tick is TICK_DIV clock cycles. The line changes level only on a tick.
- R2: A transmitted one bit is a high period of exactly T_LONG ticks.
- R3: After the eighth bit the low gap lasts T_LONG ticks. tx_done then goes high for exactly one cycle, with the line low.
- R4: Bits are sent most significant bit first. For example, 0x54 goes out as 0,1,0,1,0,1,0,0.
- R5: tx_ready is high only while the transmitter is idle. A byte is taken on a cycle where tx_valid and tx_ready are both high. tx_valid and tx_data offered while busy have no effect on the byte being sent, and no extra byte is sent.
- R6: A received high pulse of N ticks, with T_GLITCH <= N < T_START, is a data bit. The bit is one when N >= T_THRESH and zero otherwise.
- R7: After eight received data bits, rx_valid is high for exactly one cycle. rx_data then holds the byte, with the first received bit in bit 7.
- R8: A received high pulse of T_START ticks or more raises rx_start for one cycle. It adds no data bit and discards any partly received byte.
- R9: A received high pulse shorter than T_GLITCH ticks raises rx_err for one cycle. It adds no data bit and discards any partly received byte.
- R10: After reset:
  - tx_line is low and tx_ready is high;
  - tx_done, rx_valid, rx_err and rx_start are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Transmitter idle, can take a byte |
| tx_line | output | 1 | Transmitted line level |
| tx_done | output | 1 | One-cycle strobe after the final gap |
| rx_line | input | 1 | Received line level, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, rx_data holds a new byte |
| rx_err | output | 1 | One-cycle strobe, glitch pulse seen |
| rx_start | output | 1 | One-cycle strobe, start-length pulse seen |

## Verification
All 256 byte values are sent with the transmitter looped back into the receiver. For each byte, the high and low widths on the line are measured in cycles, which separates zero from one bits, normal gaps from the stretched final gap, and MSB-first from LSB-first order. The received byte is compared with the sent one.

The receiver is also driven directly with pulses one tick either side of each decision point:
- 5 against 6 ticks for the bit threshold;
- 1 against 2 ticks for the glitch limit;
- 15 against 16 ticks for the start length.

Start and glitch pulses are placed in the middle of a byte, to show that the partial byte is dropped. One byte is offered while the transmitter is busy, to show that it is ignored.

// File: rtl/pwl_codec_pkg.sv
package pwl_codec_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_HIGH, TX_LOW} tx_state_t;

  // high time in ticks for one bit value
  function automatic int hi_ticks(input logic b, input int t_short, input int t_long);
    return b ? t_long : t_short;
  endfunction

  // low gap in ticks, stretched after the final bit of a byte
  function automatic int gap_ticks(input logic last, input int t_short, input int t_long);
    return last ? t_long : t_short;
  endfunction

endpackage

// File: rtl/pwl_tick_gen.sv
module pwl_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwl_sync.sv
module pwl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwl_tx.sv
module pwl_tx
  import pwl_codec_pkg::*;
#(
  parameter int T_SHORT = 4,
  parameter int T_LONG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line,
  output logic       done
);
  localparam int TW = $clog2(T_LONG + 1);

  tx_state_t     state;
  logic [TW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    nbit;
  logic          last_bit;

  assign ready    = (state == TX_IDLE);
  assign last_bit = (nbit == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      sh    <= '0;
      nbit  <= '0;
      line  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        TX_IDLE: if (valid) begin
          sh    <= data;
          nbit  <= '0;
          state <= TX_ARM;
        end
        TX_ARM: if (tick) begin
          line  <= 1'b1;
          cnt   <= TW'(hi_ticks(sh[7], T_SHORT, T_LONG) - 1);
          state <= TX_HIGH;
        end
        TX_HIGH: if (tick) begin
          if (cnt == '0) begin
            line  <= 1'b0;
            cnt   <= TW'(gap_ticks(last_bit, T_SHORT, T_LONG) - 1);
            state <= TX_LOW;
          end else cnt <= cnt - 1'b1;
        end
        TX_LOW: if (tick) begin
          if (cnt == '0) begin
            if (last_bit) begin
              state <= TX_IDLE;
              done  <= 1'b1;
            end else begin
              nbit  <= nbit + 1'b1;
              sh    <= {sh[6:0], 1'b0};
              line  <= 1'b1;
              cnt   <= TW'(hi_ticks(sh[6], T_SHORT, T_LONG) - 1);
              state <= TX_HIGH;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwl_rx.sv
module pwl_rx #(
  parameter int T_THRESH = 6,
  parameter int T_START  = 16,
  parameter int T_GLITCH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_s,
  output logic [7:0] data,
  output logic       valid,
  output logic       err,
  output logic       start
);
  localparam int CW = $clog2(T_START + 1);
  localparam logic [CW-1:0] C_MAX = CW'(T_START);
  localparam logic [CW-1:0] C_THR = CW'(T_THRESH);
  localparam logic [CW-1:0] C_GLT = CW'(T_GLITCH);

  logic [CW-1:0] hi_len;
  logic          prev;
  logic [6:0]    sh;
  logic [2:0]    nb;
  logic          fall, is_glitch, is_start, bit_val;
  logic [7:0]    next_byte;

  assign fall      = prev & ~line_s;
  assign is_glitch = (hi_len < C_GLT);
  assign is_start  = (hi_len >= C_MAX);
  assign bit_val   = (hi_len >= C_THR);
  assign next_byte = {sh, bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_len <= '0;
      prev   <= 1'b0;
      sh     <= '0;
      nb     <= '0;
      data   <= '0;
      valid  <= 1'b0;
      err    <= 1'b0;
      start  <= 1'b0;
    end else begin
      prev  <= line_s;
      valid <= 1'b0;
      err   <= 1'b0;
      start <= 1'b0;
      if (line_s) begin
        if (tick && hi_len != C_MAX) hi_len <= hi_len + 1'b1;
      end else hi_len <= '0;
      if (fall) begin
        if (is_glitch) begin
          err <= 1'b1;
          nb  <= '0;
        end else if (is_start) begin
          start <= 1'b1;
          nb    <= '0;
        end else begin
          sh <= next_byte[6:0];
          if (nb == 3'd7) begin
            data  <= next_byte;
            valid <= 1'b1;
            nb    <= '0;
          end else nb <= nb + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwl_codec.sv
module pwl_codec #(
  parameter int TICK_DIV = 4,
  parameter int T_SHORT  = 4,
  parameter int T_LONG   = 8,
  parameter int T_THRESH = 6,
  parameter int T_START  = 16,
  parameter int T_GLITCH = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_line,
  output logic       tx_done,
  input  logic       rx_line,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_err,
  output logic       rx_start
);
  logic tick;
  logic rx_line_s;

  pwl_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwl_tx #(.T_SHORT(T_SHORT), .T_LONG(T_LONG)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready),
    .line(tx_line), .done(tx_done)
  );

  pwl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_line_s)
  );

  pwl_rx #(.T_THRESH(T_THRESH), .T_START(T_START), .T_GLITCH(T_GLITCH)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(rx_line_s),
    .data(rx_data), .valid(rx_valid), .err(rx_err), .start(rx_start)
  );
endmodule

// File: rtl/pwl_codec_checker.sv
module pwl_codec_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_line,
  input logic tx_done,
  input logic rx_valid,
  input logic rx_err,
  input logic rx_start
);
  assert_line_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line != $past(tx_line)) |-> $past(tick));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_line && !$past(tx_line)));

  assert_idle_line_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !tx_line);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rx_events_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_err, rx_start}));
endmodule

bind pwl_codec pwl_codec_checker u_pwl_codec_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .tx_done(tx_done),
  .rx_valid(rx_valid), .rx_err(rx_err), .rx_start(rx_start)
);

// File: tb/pwl_codec_bench.sv
`timescale 1ns/1ps
module pwl_codec_bench;
  localparam int DIV = 4, TS = 4, TL = 8, TH = 6, TST = 16, TG = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, drv_line = 1'b0, loop_sel = 1'b1;
  logic tx_ready, tx_line, tx_done, rx_valid, rx_err, rx_start;
  logic [7:0] rx_data;
  wire rx_line = loop_sel ? tx_line : drv_line;

  int checks = 0, errors = 0;
  int rx_cnt = 0, err_cnt = 0, start_cnt = 0;
  logic [7:0] last_rx = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwl_codec #(.TICK_DIV(DIV), .T_SHORT(TS), .T_LONG(TL), .T_THRESH(TH),
              .T_START(TST), .T_GLITCH(TG)) u_pwl_codec (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_line(tx_line), .tx_done(tx_done),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_err(rx_err), .rx_start(rx_start));

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; last_rx = rx_data; end
    if (rx_err) err_cnt++;
    if (rx_start) start_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // send one byte in loopback, measuring every pulse and gap on the line
  task automatic send_byte(input logic [7:0] b, input bit intrude);
    int h, l, base;
    bit width_ok, busy_ok;
    logic [7:0] dec;
    width_ok = 1; busy_ok = 1; dec = '0; base = rx_cnt;
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      while (!tx_line) @(negedge clk);
      if (intrude && i == 2) begin
        busy_ok = !tx_ready;
        tx_data = ~b; tx_valid = 1'b1;
      end
      h = 0;
      while (tx_line) begin h++; @(negedge clk); end
      tx_valid = 1'b0;
      l = 0;
      while (!tx_line && !tx_done) begin l++; @(negedge clk); end
      if (h == TL * DIV) dec = {dec[6:0], 1'b1};
      else if (h == TS * DIV) dec = {dec[6:0], 1'b0};
      else width_ok = 0;
      if (i < 7 && (l != TS * DIV || tx_done)) width_ok = 0;
      if (i == 7 && (l != TL * DIV || !tx_done)) width_ok = 0;
    end
    @(negedge clk);
    // R1 R2 R3: pulse and gap widths, done strobe after stretched gap
    check(width_ok && !tx_done && tx_ready, "R1/R2/R3 widths", {24'd0, dec}, {24'd0, b});
    // R4: bits decoded in line order rebuild the byte MSB first
    check(dec == b, "R4 bit order", dec, b);
    // R7: loopback receiver returns exactly one byte equal to the sent one
    check(rx_cnt == base + 1 && last_rx == b, "R7 rx byte", last_rx, b);
    if (intrude) check(busy_ok && rx_cnt == base + 1, "R5 busy ignore", rx_cnt - base, 1);
    repeat (3) @(negedge clk);
    check(rx_cnt == base + 1, "R5 no extra byte", rx_cnt - base, 1);
  endtask

  task automatic pulse(input int hi_ticks);
    @(negedge clk); drv_line = 1'b1;
    repeat (hi_ticks * DIV) @(negedge clk);
    drv_line = 1'b0;
    repeat (TS * DIV) @(negedge clk);
  endtask

  task automatic drive_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i] ? TL : TS);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int rc, ec, sc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!tx_line && tx_ready && !tx_done && !rx_valid && !rx_err && !rx_start,
          "R10 reset", {tx_line, tx_ready, tx_done, rx_valid, rx_err, rx_start}, 6'b010000);

    send_byte(8'h54, 0);   // R4 example
    send_byte(8'hA3, 1);   // R5 offer while busy
    for (int v = 0; v < 256; v++) send_byte(v[7:0], 0);

    loop_sel = 1'b0;
    repeat (10) @(negedge clk);

    // R6 boundaries: 6->1, 5->0, 8->1, 4->0, 2 (glitch limit)->0, 15 (below start)->1
    rc = rx_cnt; ec = err_cnt; sc = start_cnt;
    pulse(6); pulse(5); pulse(6); pulse(5); pulse(8); pulse(4); pulse(2); pulse(15);
    check(rx_cnt == rc + 1 && last_rx == 8'hA9, "R6 threshold", last_rx, 8'hA9);
    check(err_cnt == ec && start_cnt == sc, "R6 no events", err_cnt - ec + start_cnt - sc, 0);

    // R8: start-length pulse mid-byte discards partial bits
    rc = rx_cnt; sc = start_cnt;
    pulse(TL); pulse(TS); pulse(TL);
    pulse(TST);
    check(start_cnt == sc + 1 && rx_cnt == rc, "R8 start strobe", start_cnt - sc, 1);
    drive_byte(8'h3C);
    check(rx_cnt == rc + 1 && last_rx == 8'h3C, "R8 partial dropped", last_rx, 8'h3C);

    // R9: glitch pulse mid-byte raises error and discards partial bits
    rc = rx_cnt; ec = err_cnt;
    pulse(TS); pulse(TL); pulse(TL);
    pulse(1);
    check(err_cnt == ec + 1 && rx_cnt == rc, "R9 glitch strobe", err_cnt - ec, 1);
    drive_byte(8'hC5);
    check(rx_cnt == rc + 1 && last_rx == 8'hC5, "R9 partial dropped", last_rx, 8'hC5);

    // R7: two bytes back to back, each one strobe
    rc = rx_cnt;
    drive_byte(8'h00);
    check(rx_cnt == rc + 1 && last_rx == 8'h00, "R7 all zero", last_rx, 8'h00);
    drive_byte(8'hFF);
    check(rx_cnt == rc + 2 && last_rx == 8'hFF, "R7 all one", last_rx, 8'hFF);

    finish_run();
  end
endmodule